// File: doc/BRIEF.md
# Scratchpad Memory Function Controller

This block sits behind a single-wire slave link layer. It interprets the memory-function bytes that follow ROM selection. The link layer hands it each received byte with a strobe. It signals the start of a new transaction with a reset strobe. When the master reads a byte, the link layer asks for one with a request strobe and gets the byte on the next cycle.

Writes never go straight into the data memory. They land in a 32-byte scratchpad, together with a 16-bit target address and an ending offset. The master reads all of that back to check it. It then confirms the copy by echoing the three address bytes it read back. Only an exact echo moves the scratchpad bytes into memory. The move is a timed operation that cannot be interrupted. A read-memory command streams the data memory from any address and returns all ones past its end.

The data memory holds 2^`MEM_AW` bytes. The default is kept small for elaboration; setting `MEM_AW` to 13 gives 8192 bytes. The copy window lasts `COPY_CYCLES` clocks, with a minimum of 32.

Top module: `scratch_mem_ctrl`

## Requirements
- R1: After `rst_n` is low, `tx_valid` and `copy_busy` are 0. The target address bytes, ending offset, authorization flag and all scratchpad bytes read back as 00h.
- R2: Command 0Fh takes the low address byte (T0), then the high address byte (T1), then data bytes. Data is stored in the scratchpad from offset T0[4:0] upward. The command clears the authorization flag and sets the ending offset to the offset of the last byte stored, or to T0[4:0] if no data byte follows.
- R3: After a data byte lands at offset 31, further data bytes of that command are discarded and the ending offset stays 31.
- R4: Command AAh answers successive read requests with T0, T1, the status byte, then scratchpad bytes from offset T0[4:0] through 31, then FFh. The status byte has the authorization flag in bit 7, zeros in bits 6:5 and the ending offset in bits 4:0. Each answer appears with `tx_valid` one cycle after `tx_req`.
- R5: Command 55h followed by bytes equal to T0, T1 and the status byte, in that order, sets the authorization flag. It then writes the scratchpad bytes from offset T0[4:0] through the ending offset to memory address {T1, T0[7:5], offset}. Memory at other addresses is unchanged.
- R6: `copy_busy` rises in the cycle after the third matching authorization byte is taken. It stays high for exactly `COPY_CYCLES` cycles.
- R7: `bus_rst` has no effect while `copy_busy` is high, including its last high cycle.
- R8: After the copy window, every read request returns 00h until an accepted `bus_rst`.
- R9: If any authorization byte differs, no copy occurs and `copy_busy` stays low. Reads return FFh until `bus_rst`, and the authorization flag is unchanged.
- R10: Only command 0Fh clears the authorization flag. Read scratchpad, read memory and a failed copy leave it set.
- R11: Command F0h takes T0 and T1, loads them into the address registers, and leaves the status byte unchanged. It then streams memory from address {T1, T0}, one byte per read request.
- R12: Reads at or beyond address 2^`MEM_AW` return FFh.
- R13: An accepted `bus_rst` returns the block to command decoding. An unknown command byte, or a read with no read command active, returns FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | One-cycle strobe: link reset, next byte is a command |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a byte from the master |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle strobe: master reads a byte |
| tx_valid | output | 1 | One-cycle strobe, the cycle after `tx_req` |
| tx_byte | output | 8 | Byte returned to the master, held until the next request |
| copy_busy | output | 1 | High while a copy runs; link resets are refused |

## Verification
A link reset can arrive in the same cycle the copy window closes. The block must treat it as refused, because `copy_busy` is still high in that cycle. The bench drives `bus_rst` in the middle of the window and again in exactly the last busy cycle. It then expects 00h from the next read requests rather than a return to command decoding. A reference count of the window, kept in the bench, judges `copy_busy` at every clock.

// File: rtl/sp_pkg.sv
// Package: shared command codes, idle byte and controller states.
// Assumes: commands are single bytes received right after ROM selection.
package sp_pkg;
    localparam logic [7:0] CMD_WRITE_SP = 8'h0F;
    localparam logic [7:0] CMD_READ_SP  = 8'hAA;
    localparam logic [7:0] CMD_COPY_SP  = 8'h55;
    localparam logic [7:0] CMD_READ_MEM = 8'hF0;
    localparam logic [7:0] IDLE_BYTE    = 8'hFF;

    typedef enum logic [3:0] {
        ST_CMD, ST_WA1, ST_WA2, ST_WDATA, ST_RSP,
        ST_CA1, ST_CA2, ST_CA3, ST_COPY, ST_DONE,
        ST_MA1, ST_MA2, ST_MDATA, ST_HOLD
    } sp_state_e;
endpackage

// File: rtl/sp_addr_regs.sv
// Module: target address low/high bytes, ending offset and authorization flag.
// Assumes: load strobes are single-cycle; clearing the flag wins over setting it.
module sp_addr_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_lo,
    input  logic       ld_hi,
    input  logic [7:0] addr_byte,
    input  logic       set_end,
    input  logic [4:0] end_val,
    input  logic       clr_aa,
    input  logic       set_aa,
    output logic [7:0] ta_lo,
    output logic [7:0] ta_hi,
    output logic [7:0] es_byte,
    output logic       aa
);
    logic [4:0] end_q;

    // Purpose: hold the address registers and the flag under strobe control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_lo <= '0;
            ta_hi <= '0;
            end_q <= '0;
            aa    <= 1'b0;
        end else begin
            if (ld_lo)   ta_lo <= addr_byte;
            if (ld_hi)   ta_hi <= addr_byte;
            if (set_end) end_q <= end_val;
            if (clr_aa)      aa <= 1'b0;
            else if (set_aa) aa <= 1'b1;
        end
    end

    assign es_byte = {aa, 2'b00, end_q};
endmodule

// File: rtl/sp_scratchpad.sv
// Module: 32-byte scratchpad, one write port, two asynchronous read ports.
// Assumes: port A serves the byte stream, port B serves the copy engine.
module sp_scratchpad #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] cells [DEPTH];

    // Purpose: clear on reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/sp_data_mem.sv
// Module: byte-wide data memory of 2^AW bytes, no reset.
// Assumes: writes aimed beyond the array are dropped; the reader range-checks itself.
module sp_data_mem #(
    parameter int AW     = 11,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [15:0]   waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];
    logic       w_in_range;

    assign w_in_range = {1'b0, waddr} < 17'(DEPTH);

    // Purpose: store a byte when the write address falls inside the array.
    always_ff @(posedge clk) begin
        if (we && w_in_range) cells[waddr[AW-1:0]] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sp_copy_engine.sv
// Module: timed copy of scratchpad offsets start..end into data memory.
// Assumes: address registers stay stable for the whole window; one byte moves per
// cycle, so a window of at least 32 cycles always finishes the transfer.
module sp_copy_engine #(
    parameter int COPY_CYCLES = 64,
    localparam int CYC = (COPY_CYCLES < 32) ? 32 : COPY_CYCLES,
    localparam int CW  = $clog2(CYC + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  start_off,
    input  logic [4:0]  end_off,
    input  logic [10:0] page_hi,
    output logic        busy,
    output logic        last,
    output logic [4:0]  sp_idx,
    output logic        mem_we,
    output logic [15:0] mem_addr
);
    logic [CW-1:0] cnt;
    logic [4:0]    span;

    assign span     = end_off - start_off;
    assign sp_idx   = start_off + cnt[4:0];
    assign mem_we   = busy && (cnt <= CW'(span));
    assign mem_addr = {page_hi, sp_idx};
    assign last     = busy && (cnt == CW'(CYC - 1));

    // Purpose: run the busy window and step the byte counter through it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scratch_mem_ctrl.sv
// Module: memory-function command controller (write/read scratchpad, authorized
// copy, read memory) behind a byte-level link layer.
// Assumes: rx_valid, tx_req and bus_rst are one-cycle strobes; an accepted bus_rst
// takes priority over a byte received in the same cycle.
module scratch_mem_ctrl
    import sp_pkg::*;
#(
    parameter int MEM_AW      = 11,
    parameter int COPY_CYCLES = 64,
    localparam int MEM_DEPTH  = 1 << MEM_AW
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       copy_busy
);
    sp_state_e   state, nxt;
    logic [4:0]  ptr;
    logic [1:0]  phase;
    logic        sp_end;
    logic [16:0] rd_addr;

    logic        rst_ok, rx_go;
    logic        ld_lo, ld_hi, set_end, clr_aa, set_aa, sp_we, cp_start;
    logic [4:0]  end_val;
    logic [7:0]  ta_lo, ta_hi, es_byte;
    logic        aa;
    logic [7:0]  sp_rd, sp_cp;
    logic [4:0]  cp_idx;
    logic        cp_last, mem_we;
    logic [15:0] mem_waddr;
    logic [7:0]  mem_rd;
    logic        rd_in_range;

    assign rst_ok      = bus_rst && !copy_busy;
    assign rx_go       = rx_valid && !rst_ok;
    assign rd_in_range = rd_addr < 17'(MEM_DEPTH);

    sp_addr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi), .addr_byte(rx_byte),
        .set_end(set_end), .end_val(end_val), .clr_aa(clr_aa), .set_aa(set_aa),
        .ta_lo(ta_lo), .ta_hi(ta_hi), .es_byte(es_byte), .aa(aa)
    );

    sp_scratchpad #(.DEPTH(32)) u_sp (
        .clk(clk), .rst_n(rst_n), .we(sp_we), .waddr(ptr), .wdata(rx_byte),
        .raddr_a(ptr), .rdata_a(sp_rd), .raddr_b(cp_idx), .rdata_b(sp_cp)
    );

    sp_copy_engine #(.COPY_CYCLES(COPY_CYCLES)) u_copy (
        .clk(clk), .rst_n(rst_n), .start(cp_start), .start_off(ta_lo[4:0]),
        .end_off(es_byte[4:0]), .page_hi({ta_hi, ta_lo[7:5]}), .busy(copy_busy),
        .last(cp_last), .sp_idx(cp_idx), .mem_we(mem_we), .mem_addr(mem_waddr)
    );

    sp_data_mem #(.AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(sp_cp),
        .raddr(rd_addr[MEM_AW-1:0]), .rdata(mem_rd)
    );

    // Purpose: decode the received byte against the current state into strobes.
    always_comb begin
        nxt      = state;
        ld_lo    = 1'b0;
        ld_hi    = 1'b0;
        set_end  = 1'b0;
        end_val  = ptr;
        clr_aa   = 1'b0;
        set_aa   = 1'b0;
        sp_we    = 1'b0;
        cp_start = 1'b0;
        if (state == ST_COPY) begin
            if (cp_last) nxt = ST_DONE;
        end else if (rst_ok) begin
            nxt = ST_CMD;
        end else if (rx_go) begin
            unique case (state)
                ST_CMD: begin
                    unique case (rx_byte)
                        CMD_WRITE_SP: begin nxt = ST_WA1; clr_aa = 1'b1; end
                        CMD_READ_SP:  nxt = ST_RSP;
                        CMD_COPY_SP:  nxt = ST_CA1;
                        CMD_READ_MEM: nxt = ST_MA1;
                        default:      nxt = ST_HOLD;
                    endcase
                end
                ST_WA1: begin
                    ld_lo = 1'b1; set_end = 1'b1; end_val = rx_byte[4:0]; nxt = ST_WA2;
                end
                ST_WA2: begin ld_hi = 1'b1; nxt = ST_WDATA; end
                ST_WDATA: begin
                    sp_we = 1'b1; set_end = 1'b1;
                    nxt = (ptr == 5'd31) ? ST_HOLD : ST_WDATA;
                end
                ST_CA1: nxt = (rx_byte == ta_lo) ? ST_CA2 : ST_HOLD;
                ST_CA2: nxt = (rx_byte == ta_hi) ? ST_CA3 : ST_HOLD;
                ST_CA3: begin
                    if (rx_byte == es_byte) begin
                        set_aa = 1'b1; cp_start = 1'b1; nxt = ST_COPY;
                    end else begin
                        nxt = ST_HOLD;
                    end
                end
                ST_MA1: begin ld_lo = 1'b1; nxt = ST_MA2; end
                ST_MA2: begin ld_hi = 1'b1; nxt = ST_MDATA; end
                default: nxt = state;
            endcase
        end
    end

    // Purpose: advance the state, the byte pointers and the transmit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            ptr      <= '0;
            phase    <= '0;
            sp_end   <= 1'b0;
            rd_addr  <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= IDLE_BYTE;
        end else begin
            state    <= nxt;
            tx_valid <= tx_req;
            if (rx_go && state == ST_CMD && rx_byte == CMD_READ_SP) begin
                phase  <= '0;
                sp_end <= 1'b0;
            end
            if (rx_go && state == ST_WA1) ptr <= rx_byte[4:0];
            if (rx_go && state == ST_WDATA && ptr != 5'd31) ptr <= ptr + 1'b1;
            if (rx_go && state == ST_MA2) rd_addr <= {1'b0, rx_byte, ta_lo};
            if (tx_req) begin
                unique case (state)
                    ST_RSP: begin
                        unique case (phase)
                            2'd0: begin tx_byte <= ta_lo; phase <= 2'd1; end
                            2'd1: begin tx_byte <= ta_hi; phase <= 2'd2; end
                            2'd2: begin
                                tx_byte <= es_byte; ptr <= ta_lo[4:0]; phase <= 2'd3;
                            end
                            default: begin
                                tx_byte <= sp_end ? IDLE_BYTE : sp_rd;
                                if (ptr == 5'd31) sp_end <= 1'b1;
                                else              ptr    <= ptr + 1'b1;
                            end
                        endcase
                    end
                    ST_MDATA: begin
                        tx_byte <= rd_in_range ? mem_rd : IDLE_BYTE;
                        if (rd_in_range) rd_addr <= rd_addr + 1'b1;
                    end
                    ST_DONE: tx_byte <= 8'h00;
                    default: tx_byte <= IDLE_BYTE;
                endcase
            end
        end
    end

    // R4: an answer only ever follows a read request.
    assert_tx_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R5: memory is written only with authorization granted.
    assert_mem_write_authorized_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> aa);

    // R6: the busy window opens only on the third authorization byte.
    assert_busy_opens_on_auth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_busy) |-> $past(state == ST_CA3 && rx_valid));

    // R7: a link reset during the window does not return to command decoding.
    assert_reset_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_busy && bus_rst) |=> (state == ST_COPY || state == ST_DONE));

    // R8: reads after the copy answer zero.
    assert_done_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(state == ST_DONE && tx_req)) |-> (tx_byte == 8'h00));

    // R10: the flag falls only on a write-scratchpad command byte.
    assert_aa_clear_only_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aa) |-> $past(state == ST_CMD && rx_go && rx_byte == CMD_WRITE_SP));
endmodule

// File: tb/scratch_mem_ctrl_bench.sv
module scratch_mem_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int CC         = 40;
    localparam int MEM        = 1 << AW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       copy_busy;

    int n_chk = 0;
    int n_err = 0;
    int exp_left = 0;
    bit mon_on = 1'b0;

    // reference model state
    logic [7:0] m_sp [32];
    logic [7:0] m_mem [int];
    logic [7:0] m_ta1, m_ta2;
    logic [4:0] m_end;
    logic       m_aa;

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_mem_ctrl #(.MEM_AW(AW), .COPY_CYCLES(CC)) u_scratch_mem_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .copy_busy(copy_busy)
    );

    function automatic logic [7:0] m_es();
        return {m_aa, 2'b00, m_end};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // copy window reference, judged every clock (R6)
    always @(negedge clk) begin
        if (mon_on) begin
            n_chk++;
            if (copy_busy !== (exp_left > 0)) begin
                n_err++;
                $display("FAIL R6: copy_busy got %0b expected %0b", copy_busy, exp_left > 0);
            end
            if (exp_left > 0) exp_left--;
        end
    end

    task automatic send(input logic [7:0] b, input bit arm);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk);
        #1;
        if (arm) exp_left = CC;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] exp);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        chk({req, " valid"}, {7'd0, tx_valid}, 8'd1);
        chk(req, tx_byte, exp);
    endtask

    task automatic link_reset();
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    task automatic write_sp(input logic [7:0] t1, input logic [7:0] t2, input logic [7:0] d[$]);
        logic [4:0] p;
        bit full;
        link_reset();
        send(8'h0F, 1'b0);
        m_aa = 1'b0;
        send(t1, 1'b0);
        m_ta1 = t1;
        m_end = t1[4:0];
        send(t2, 1'b0);
        m_ta2 = t2;
        p = t1[4:0];
        full = 1'b0;
        foreach (d[i]) begin
            send(d[i], 1'b0);
            if (!full) begin
                m_sp[p] = d[i];
                m_end = p;
                if (p == 5'd31) full = 1'b1;
                else            p = p + 1'b1;
            end
        end
    endtask

    task automatic read_sp(input string req, input int n_data, input int n_ff);
        int p;
        link_reset();
        send(8'hAA, 1'b0);
        expect_rd(req, m_ta1);
        expect_rd(req, m_ta2);
        expect_rd(req, m_es());
        p = int'(m_ta1[4:0]);
        for (int i = 0; i < n_data; i++) expect_rd(req, m_sp[p + i]);
        for (int i = 0; i < n_ff; i++) expect_rd(req, 8'hFF);
    endtask

    task automatic do_copy(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                           output bit ok);
        int span;
        logic [4:0] off;
        int addr;
        ok = (a == m_ta1) && (b == m_ta2) && (c == m_es());
        link_reset();
        send(8'h55, 1'b0);
        send(a, 1'b0);
        send(b, 1'b0);
        send(c, ok);
        if (ok) begin
            m_aa = 1'b1;
            span = int'(5'(m_end - m_ta1[4:0]));
            for (int k = 0; k <= span; k++) begin
                off = 5'(m_ta1[4:0] + 5'(k));
                addr = int'({m_ta2, m_ta1[7:5], off});
                if (addr < MEM) m_mem[addr] = m_sp[off];
            end
        end
    endtask

    task automatic read_mem(input string req, input int addr, input int n);
        int a;
        link_reset();
        send(8'hF0, 1'b0);
        send(addr[7:0], 1'b0);
        send(addr[15:8], 1'b0);
        m_ta1 = addr[7:0];
        m_ta2 = addr[15:8];
        for (int i = 0; i < n; i++) begin
            a = addr + i;
            if (a >= MEM)                expect_rd(req, 8'hFF);
            else if (m_mem.exists(a))    expect_rd(req, m_mem[a]);
            else                         expect_rd(req, 8'hxx);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        bit ok;
        for (int i = 0; i < 32; i++) m_sp[i] = 8'h00;
        m_ta1 = 8'h00; m_ta2 = 8'h00; m_end = 5'd0; m_aa = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
        chk("R1 copy_busy", {7'd0, copy_busy}, 8'd0);
        mon_on = 1'b1;
        read_sp("R1", 2, 0);

        // R13: idle read and unknown command answer FFh, reset re-enters decode
        link_reset();
        expect_rd("R13", 8'hFF);
        send(8'h33, 1'b0);
        expect_rd("R13", 8'hFF);
        read_sp("R13", 0, 0);

        // R2 R4: write two bytes at offset 6, read back through offset 31 then FFh
        write_sp(8'h26, 8'h00, '{8'hA1, 8'hB2});
        read_sp("R2 R4", 26, 2);

        // R5 R6 R7 R8: matching copy; resets mid-window and in the last busy cycle
        do_copy(8'h26, 8'h00, 8'h07, ok);
        chk("R5 auth", {7'd0, ok}, 8'd1);
        for (int i = 1; i < CC; i++) begin
            @(negedge clk);
            bus_rst = (i == 4) || (i == CC - 1);
        end
        @(negedge clk);
        bus_rst = 1'b0;
        expect_rd("R7 R8", 8'h00);
        expect_rd("R8", 8'h00);
        read_sp("R5 flag", 0, 0);

        // R11 R10: memory stream, address loaded, status byte and flag kept
        read_mem("R5 R11", 16'h0026, 2);
        read_mem("R11", 16'h0027, 1);
        read_sp("R10 R11", 0, 0);

        // R3: write stops at offset 31, flag cleared by write
        write_sp(8'hFD, 8'h07, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
        read_sp("R3 R10", 3, 1);

        // R12: copy into the last page, stream across the end of memory
        do_copy(8'hFD, 8'h07, 8'h1F, ok);
        repeat (CC + 2) @(negedge clk);
        read_mem("R12", MEM - 3, 5);
        read_mem("R12", MEM + 256, 2);

        // R9: mismatching copy leaves memory and flag, answers FFh
        write_sp(8'h26, 8'h00, '{8'hC3});
        do_copy(8'h26, 8'h00, 8'h07, ok);
        expect_rd("R9", 8'hFF);
        expect_rd("R9", 8'hFF);
        read_mem("R9", 16'h0026, 2);
        read_sp("R9", 1, 0);

        // R10: a failed copy after a good one keeps the flag set
        do_copy(8'h26, 8'h00, 8'h06, ok);
        repeat (CC + 2) @(negedge clk);
        do_copy(8'h00, 8'h00, 8'h00, ok);
        read_sp("R10", 1, 0);

        // R2: write command with no data byte sets end to the start offset
        write_sp(8'h4A, 8'h01, '{});
        read_sp("R2", 0, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule